// File: doc/BRIEF.md
# Delay Line Phase Programming Sequencer

This block owns the control bits of a programmable sampling delay line and steps them in a fixed order. It offers two commands. The bring-up command powers the line down and holds it in reset, loads a frequency range code derived from the current interface clock rate, then releases the line, enables it and its clock output, and waits for the line to report lock. The phase command moves the line to external recovery mode with its clock output gated. It then loads a new sampling phase as a reflected Gray code, ungates the output and hands control back to internal recovery.

Each control change takes one clock cycle. The two status inputs from the line, lock and clock-output-active, are polled in wait states. These waits are bounded by a count of microsecond ticks supplied from outside, and an expired wait ends the command with an error pulse. A power-save bit requested by configuration is held off for the duration of a bring-up and comes back once lock is seen.

Top module: `dly_phase_seq`

## Requirements
- R1: After reset every delay-line control output, `dl_freq`, `dl_gray`, `busy`, `done` and `err` are 0.
- R2: A bring-up (`cmd_op`=0) accepted at edge E1 drives, one change per edge: E2 `dl_rst`=1, E3 `dl_pdn`=1, E4 `dl_freq` loaded, E5 `dl_rst`=0, E6 `dl_pdn`=0, E7 `dl_en`=1, E8 `dl_clkout_en`=1. From E9 on it waits for `lock_stat`=1, and `dl_freq` only changes while `dl_rst` and `dl_pdn` are both 1.
- R3: The loaded frequency code is the count of the bounds 112, 125, 137, 150, 162, 175, 187 that `rate_mhz` exceeds (0 for rates up to 112 MHz, 7 above 187 MHz).
- R4: `dl_pwr_save` follows `pwr_save_en` except from the bring-up acceptance edge until lock is seen. If the lock wait times out, it stays low until a later bring-up reaches lock.
- R5: In the lock wait, the 50th `us_tick` seen without lock ends the bring-up with `err`; 49 ticks do not.
- R6: A phase command (`cmd_op`=1) at E1 sets `dl_cdr_en`=0, `dl_clkout_en`=0, `dl_cdr_ext`=1 and `dl_en`=1. It then waits for `clkout_stat`=0, loads `dl_gray` on the edge that sees it, sets `dl_clkout_en`=1 on the next edge, and waits for `clkout_stat`=1. On that edge it sets `dl_cdr_en`=1 and `dl_cdr_ext`=0. `dl_gray` never changes while `dl_clkout_en` is 1.
- R7: `dl_gray` equals `cmd_phase ^ (cmd_phase >> 1)` for the accepted phase (0..15 maps to 0,1,3,2,6,7,5,4,C,D,F,E,A,B,9,8).
- R8: Each of the two clock-output waits ends the phase command with `err` on its 50th `us_tick` if the status has not arrived. When the low wait times out, `dl_gray` is left unchanged.
- R9: `busy` is 1 from the acceptance edge until completion. A `cmd_valid` while busy is ignored.
- R10: `done` (success) or `err` (failure) is a one-cycle pulse in the first cycle with `busy`=0. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_op | input | 1 | 0 = bring-up, 1 = set phase |
| cmd_phase | input | PHASE_W | Phase number for a set-phase command |
| rate_mhz | input | RATE_W | Current interface clock rate in MHz |
| pwr_save_en | input | 1 | Configured power-save request |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| lock_stat | input | 1 | Lock status from the delay line |
| clkout_stat | input | 1 | Clock output active status from the delay line |
| dl_pwr_save | output | 1 | Power-save control |
| dl_rst | output | 1 | Line reset control |
| dl_pdn | output | 1 | Line power-down control |
| dl_freq | output | 3 | Frequency range code |
| dl_en | output | 1 | Line enable |
| dl_clkout_en | output | 1 | Clock output enable |
| dl_cdr_en | output | 1 | Internal clock recovery enable |
| dl_cdr_ext | output | 1 | External recovery mode select |
| dl_gray | output | PHASE_W | Gray-coded phase |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Success pulse |
| err | output | 1 | Timeout pulse |

## Verification
The assertions assume `us_tick` pulses only a single cycle at a time and that the status inputs are stable in the sampled cycle. They also assume a new command comes only after the previous completion pulse. The bench drives every input at the falling edge, produces ticks only through a task that raises them for exactly one cycle, and starts the next command only after it has seen `done` or `err`. The clock output status is modelled by a responder that follows `dl_clkout_en` one cycle late. Timeout cases switch the responder off and hold the status at a fixed level.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int unsigned FREQ_W     = 3;
  localparam int unsigned NUM_BOUNDS = 7;
  localparam int unsigned FREQ_BOUND [NUM_BOUNDS] = '{112, 125, 137, 150, 162, 175, 187};

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_I_RST,
    ST_I_PDN,
    ST_I_FREQ,
    ST_I_RSTOFF,
    ST_I_PDNOFF,
    ST_I_EN,
    ST_I_CLKOUT,
    ST_I_LOCK,
    ST_P_WLOW,
    ST_P_CLKON,
    ST_P_WHIGH
  } seq_state_e;

  typedef struct packed {
    logic              ps_hold;
    logic              rst;
    logic              pdn;
    logic [FREQ_W-1:0] freq;
    logic              en;
    logic              clkout_en;
    logic              cdr_en;
    logic              cdr_ext;
  } line_ctrl_t;
endpackage

// File: rtl/dps_freq_map.sv
module dps_freq_map
  import dps_pkg::*;
#(
  parameter int unsigned RATE_W = 8
) (
  input  logic [RATE_W-1:0] rate_mhz,
  output logic [FREQ_W-1:0] code
);
  logic [NUM_BOUNDS-1:0] above;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BOUNDS; gi++) begin : g_cmp
      assign above[gi] = (32'(rate_mhz) > FREQ_BOUND[gi]);
    end
  endgenerate

  always_comb begin
    code = '0;
    for (int i = 0; i < NUM_BOUNDS; i++) begin
      if (above[i]) code = FREQ_W'(code + 1'b1);
    end
  end
endmodule

// File: rtl/dps_gray_enc.sv
module dps_gray_enc #(
  parameter int unsigned PHASE_W = 4
) (
  input  logic [PHASE_W-1:0] bin,
  output logic [PHASE_W-1:0] gray
);
  assign gray[PHASE_W-1] = bin[PHASE_W-1];
  genvar gi;
  generate
    for (gi = 0; gi < PHASE_W-1; gi++) begin : g_bit
      assign gray[gi] = bin[gi] ^ bin[gi+1];
    end
  endgenerate
endmodule

// File: rtl/dps_tick_timer.sv
module dps_tick_timer #(
  parameter int unsigned TMO_TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic expired
);
  localparam int unsigned CNT_W = (TMO_TICKS > 1) ? $clog2(TMO_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en  = clr || (tick && (cnt_q != LAST));
  assign expired = !clr && tick && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                 cnt_d = '0;
    else if (cnt_q != LAST)  cnt_d = CNT_W'(cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R8
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/dly_phase_seq.sv
module dly_phase_seq
  import dps_pkg::*;
#(
  parameter int unsigned PHASE_W   = 4,
  parameter int unsigned RATE_W    = 8,
  parameter int unsigned TMO_TICKS = 50
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic               cmd_op,
  input  logic [PHASE_W-1:0] cmd_phase,
  input  logic [RATE_W-1:0]  rate_mhz,
  input  logic               pwr_save_en,
  input  logic               us_tick,
  input  logic               lock_stat,
  input  logic               clkout_stat,
  output logic               dl_pwr_save,
  output logic               dl_rst,
  output logic               dl_pdn,
  output logic [2:0]         dl_freq,
  output logic               dl_en,
  output logic               dl_clkout_en,
  output logic               dl_cdr_en,
  output logic               dl_cdr_ext,
  output logic [PHASE_W-1:0] dl_gray,
  output logic               busy,
  output logic               done,
  output logic               err
);
  seq_state_e         state_q, state_d;
  line_ctrl_t         ctrl_q, ctrl_d;
  logic [PHASE_W-1:0] gray_q, gray_d, gray_new;
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic [FREQ_W-1:0]  freq_code;
  logic               done_d, err_d, done_q, err_q;
  logic               in_wait, tmo;

  dps_freq_map #(.RATE_W(RATE_W)) u_freq (
    .rate_mhz (rate_mhz),
    .code     (freq_code)
  );

  dps_gray_enc #(.PHASE_W(PHASE_W)) u_gray (
    .bin  (phase_q),
    .gray (gray_new)
  );

  assign in_wait = (state_q == ST_I_LOCK) || (state_q == ST_P_WLOW) ||
                   (state_q == ST_P_WHIGH);

  dps_tick_timer #(.TMO_TICKS(TMO_TICKS)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!in_wait),
    .tick    (us_tick),
    .expired (tmo)
  );

  // Next-state and control update
  always_comb begin
    state_d = state_q;
    ctrl_d  = ctrl_q;
    gray_d  = gray_q;
    phase_d = phase_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          if (!cmd_op) begin
            ctrl_d.ps_hold = 1'b1;
            state_d        = ST_I_RST;
          end else begin
            phase_d           = cmd_phase;
            ctrl_d.cdr_en     = 1'b0;
            ctrl_d.clkout_en  = 1'b0;
            ctrl_d.cdr_ext    = 1'b1;
            ctrl_d.en         = 1'b1;
            state_d           = ST_P_WLOW;
          end
        end
      end
      ST_I_RST:    begin ctrl_d.rst = 1'b1;          state_d = ST_I_PDN;    end
      ST_I_PDN:    begin ctrl_d.pdn = 1'b1;          state_d = ST_I_FREQ;   end
      ST_I_FREQ:   begin ctrl_d.freq = freq_code;    state_d = ST_I_RSTOFF; end
      ST_I_RSTOFF: begin ctrl_d.rst = 1'b0;          state_d = ST_I_PDNOFF; end
      ST_I_PDNOFF: begin ctrl_d.pdn = 1'b0;          state_d = ST_I_EN;     end
      ST_I_EN:     begin ctrl_d.en = 1'b1;           state_d = ST_I_CLKOUT; end
      ST_I_CLKOUT: begin ctrl_d.clkout_en = 1'b1;    state_d = ST_I_LOCK;   end
      ST_I_LOCK: begin
        if (lock_stat) begin
          ctrl_d.ps_hold = 1'b0;
          done_d         = 1'b1;
          state_d        = ST_IDLE;
        end else if (tmo) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_P_WLOW: begin
        if (!clkout_stat) begin
          gray_d  = gray_new;
          state_d = ST_P_CLKON;
        end else if (tmo) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_P_CLKON: begin
        ctrl_d.clkout_en = 1'b1;
        state_d          = ST_P_WHIGH;
      end
      ST_P_WHIGH: begin
        if (clkout_stat) begin
          ctrl_d.cdr_en  = 1'b1;
          ctrl_d.cdr_ext = 1'b0;
          done_d         = 1'b1;
          state_d        = ST_IDLE;
        end else if (tmo) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctrl_q  <= '0;
      gray_q  <= '0;
      phase_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ctrl_q  <= ctrl_d;
      gray_q  <= gray_d;
      phase_q <= phase_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign dl_pwr_save  = pwr_save_en && !ctrl_q.ps_hold;
  assign dl_rst       = ctrl_q.rst;
  assign dl_pdn       = ctrl_q.pdn;
  assign dl_freq      = ctrl_q.freq;
  assign dl_en        = ctrl_q.en;
  assign dl_clkout_en = ctrl_q.clkout_en;
  assign dl_cdr_en    = ctrl_q.cdr_en;
  assign dl_cdr_ext   = ctrl_q.cdr_ext;
  assign dl_gray      = gray_q;
  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign err          = err_q;

  // R2
  freq_under_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dl_freq) |-> (dl_rst && dl_pdn));

  // R6
  gray_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dl_gray) |-> !dl_clkout_en);

  // R6
  cdr_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dl_cdr_en) |-> (dl_clkout_en && !dl_cdr_ext));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy);

  // R10
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |=> !(done || err));

  // R10
  done_xor_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));

  // R4
  ps_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_rst || dl_pdn) |-> !dl_pwr_save);
endmodule

// File: tb/dly_phase_seq_test.sv
module dly_phase_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_op = 1'b0;
  logic [3:0] cmd_phase = '0;
  logic [7:0] rate_mhz = '0;
  logic       pwr_save_en = 1'b0;
  logic       us_tick = 1'b0;
  logic       lock_stat = 1'b1;
  logic       resp_on = 1'b1;
  logic       resp_val = 1'b0;
  logic       forced_stat = 1'b0;
  logic       clkout_stat;

  logic       dl_pwr_save, dl_rst, dl_pdn, dl_en, dl_clkout_en, dl_cdr_en, dl_cdr_ext;
  logic [2:0] dl_freq;
  logic [3:0] dl_gray;
  logic       busy, done, err;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  always @(negedge clk) resp_val <= dl_clkout_en;
  assign clkout_stat = resp_on ? resp_val : forced_stat;

  dly_phase_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_phase(cmd_phase), .rate_mhz(rate_mhz), .pwr_save_en(pwr_save_en),
    .us_tick(us_tick), .lock_stat(lock_stat), .clkout_stat(clkout_stat),
    .dl_pwr_save(dl_pwr_save), .dl_rst(dl_rst), .dl_pdn(dl_pdn),
    .dl_freq(dl_freq), .dl_en(dl_en), .dl_clkout_en(dl_clkout_en),
    .dl_cdr_en(dl_cdr_en), .dl_cdr_ext(dl_cdr_ext), .dl_gray(dl_gray),
    .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int freq_of(input int r);
    int c = 0;
    if (r > 112) c++;
    if (r > 125) c++;
    if (r > 137) c++;
    if (r > 150) c++;
    if (r > 162) c++;
    if (r > 175) c++;
    if (r > 187) c++;
    return c;
  endfunction

  // returns at the falling edge after the acceptance edge
  task automatic issue(input logic op, input logic [3:0] ph);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_phase = ph;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_end(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done || err) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); us_tick = 1'b1;
      @(negedge clk); us_tick = 1'b0;
    end
  endtask

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 ctrl", {dl_pwr_save, dl_rst, dl_pdn, dl_en, dl_clkout_en, dl_cdr_en, dl_cdr_ext}, 0);
    chk("R1 freq/gray", {dl_freq, dl_gray}, 0);
    chk("R1 status", {busy, done, err}, 0);
    rst_n = 1'b1;

    // R2 / R4 bring-up order, rate 150 -> code 3
    pwr_save_en = 1'b1; rate_mhz = 8'd150;
    @(negedge clk);
    chk("R4 ps before", dl_pwr_save, 1);
    issue(1'b0, 4'd0);
    chk("R4 ps held E1", dl_pwr_save, 0);
    chk("R9 busy E1", busy, 1);
    chk("R2 rst E1", dl_rst, 0);
    @(negedge clk); chk("R2 rst E2", dl_rst, 1); chk("R2 pdn E2", dl_pdn, 0);
    @(negedge clk); chk("R2 pdn E3", dl_pdn, 1); chk("R2 freq E3", dl_freq, 0);
    @(negedge clk); chk("R2 freq E4", dl_freq, 3); chk("R2 rst E4", dl_rst, 1);
    @(negedge clk); chk("R2 rst E5", dl_rst, 0); chk("R2 pdn E5", dl_pdn, 1);
    @(negedge clk); chk("R2 pdn E6", dl_pdn, 0); chk("R2 en E6", dl_en, 0);
    @(negedge clk); chk("R2 en E7", dl_en, 1); chk("R2 clkout E7", dl_clkout_en, 0);
    @(negedge clk); chk("R2 clkout E8", dl_clkout_en, 1); chk("R10 done E8", done, 0);
    chk("R4 ps held E8", dl_pwr_save, 0);
    @(negedge clk); chk("R10 done E9", done, 1); chk("R10 busy E9", busy, 0);
    chk("R4 ps restored", dl_pwr_save, 1);
    @(negedge clk); chk("R10 done pulse", done, 0);

    // R3 exhaustive rate sweep
    for (int r = 0; r < 256; r++) begin
      rate_mhz = 8'(r);
      issue(1'b0, 4'd0);
      wait_end(ok);
      chk("R3 done", {ok, done, err}, 6);
      chk($sformatf("R3 freq rate=%0d", r), dl_freq, freq_of(r));
    end

    // R6 phase order for phase 5
    issue(1'b1, 4'd5);
    chk("R6 clkout E1", dl_clkout_en, 0); chk("R6 ext E1", dl_cdr_ext, 1);
    chk("R6 cdr E1", dl_cdr_en, 0); chk("R6 en E1", dl_en, 1);
    chk("R6 gray E1", dl_gray, 0);
    @(negedge clk); chk("R7 gray E2", dl_gray, 5 ^ (5 >> 1)); chk("R6 clkout E2", dl_clkout_en, 0);
    @(negedge clk); chk("R6 clkout E3", dl_clkout_en, 1); chk("R6 ext E3", dl_cdr_ext, 1);
    @(negedge clk); chk("R6 cdr E4", dl_cdr_en, 1); chk("R6 ext E4", dl_cdr_ext, 0);
    chk("R10 done E4", done, 1);

    // R7 all phases
    for (int p = 0; p < 16; p++) begin
      issue(1'b1, 4'(p));
      wait_end(ok);
      chk("R7 done", {ok, done, err}, 6);
      chk($sformatf("R7 gray p=%0d", p), dl_gray, p ^ (p >> 1));
      chk("R6 final", {dl_cdr_en, dl_cdr_ext, dl_clkout_en}, 5);
    end

    // R9 command during bring-up ignored (gray is 8 from phase 15)
    issue(1'b0, 4'd0);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 1'b1; cmd_phase = 4'd3;
    @(negedge clk); cmd_valid = 1'b0;
    wait_end(ok);
    chk("R9 done", {ok, done, err}, 6);
    chk("R9 gray kept", dl_gray, 8);
    chk("R9 ext kept", dl_cdr_ext, 0);
    @(negedge clk); chk("R9 idle", busy, 0);

    // R8 high-wait timeout
    resp_on = 1'b0; forced_stat = 1'b0;
    issue(1'b1, 4'd6);
    @(negedge clk); @(negedge clk);
    chk("R8 clkout on", dl_clkout_en, 1);
    tick_n(49);
    chk("R8 49 ticks busy", {busy, err}, 2);
    tick_n(1);
    chk("R8 high err", {busy, done, err}, 1);
    chk("R8 cdr off", dl_cdr_en, 0);
    chk("R7 gray p6", dl_gray, 5);

    // R8 low-wait timeout keeps gray
    forced_stat = 1'b1;
    issue(1'b1, 4'd12);
    tick_n(49);
    chk("R8 low 49 busy", {busy, err}, 2);
    tick_n(1);
    chk("R8 low err", {busy, done, err}, 1);
    chk("R8 gray kept", dl_gray, 5);
    resp_on = 1'b1;

    // R5 / R4 lock timeout
    lock_stat = 1'b0;
    issue(1'b0, 4'd0);
    repeat (7) @(negedge clk);
    tick_n(49);
    chk("R5 49 busy", {busy, err}, 2);
    tick_n(1);
    chk("R5 lock err", {busy, done, err}, 1);
    repeat (3) @(negedge clk);
    chk("R4 ps stays off", dl_pwr_save, 0);
    lock_stat = 1'b1;
    issue(1'b0, 4'd0);
    wait_end(ok);
    chk("R5 retry done", {ok, done, err}, 6);
    chk("R4 ps back", dl_pwr_save, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule